// File: doc/BRIEF.md
# Multicycle Instruction Sequencer with Traps and Interrupts

This block is the control core of a small register machine. It steps through fetch, decode and execute for one instruction at a time. It reaches primary memory through a memory address register and a memory data register, and it issues one read or write command at a time. A read takes three steps: the sequencer loads the address register, asserts the read command for one cycle, and takes the returned word into the data register in the cycle that follows. The execute path is a small ALU with four registers. It covers load, load-immediate, store, add and subtract, and it keeps a zero flag and a negative flag.

The sequencer also carries a global interrupt-enable bit and a user/supervisor mode bit. A level-sensitive interrupt request is examined once per instruction, right after the fetch, and never while an instruction is running. On interrupt entry the enable bit is cleared first. The program counter is then written to memory word 0, and the program counter is reloaded from memory word 1. A trap instruction selects one of four handlers through the vector words that start at address 1000. It forces supervisor mode in the same step. Execution stops when a halt instruction sets the halted flag, which starts out clear.

Top module: `seq_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it: pc is 0, int_en is 0, mode_sup is 1, halted is 0, and neither mem_rd nor mem_wr is asserted.
- R2: A memory read drives the address from the address register. mem_rd is high for exactly one cycle, with mem_addr unchanged in the next cycle, when mem_rdata is taken. The first read after reset is for address 0 and is issued in the cycle after the first clock edge. mem_rd and mem_wr are never high together.
- R3: An instruction is 16 bits. Bits 15:12 hold the opcode, bits 11:10 hold the register field and bits 9:0 hold the operand. The opcodes are 0 halt, 1 load, 2 load-immediate, 3 store, 4 add, 5 subtract, 6 trap, 7 enable-interrupts and 8 enter-user-mode. Any other opcode does nothing except advance the pc.
- R4: Load copies memory[operand] into the selected register. Load-immediate writes the zero-extended operand. Store writes the selected register to memory[operand].
- R5: Add and subtract compute reg[field] = reg[field] ± reg[operand bits 1:0] in 16-bit two's complement. Only these two instructions update flag_z (result is zero) and flag_n (bit 15 of the result).
- R6: Every instruction other than halt and trap advances the pc by one. A register-only instruction takes 5 clock edges from the start of its fetch, a store takes 6, and a load or trap takes 7.
- R7: Halt raises halted 5 edges after its fetch begins. From then on the pc holds the address of the halt and no memory command is issued.
- R8: Trap n (operand bits 1:0) loads the pc from memory[1000+n] and sets mode_sup. An interrupt request that arrives while the trap is running is taken only at the next instruction boundary.
- R9: After each fetch, if the interrupt request is high and int_en is 1, the fetched instruction is dropped. int_en is cleared, the address of the dropped instruction is written to memory word 0, the pc is loaded from memory word 1, and mode_sup is set.
- R10: While int_en is 0, the interrupt request has no effect on program flow or on memory word 0.
- R11: Enable-interrupts sets int_en. Enter-user-mode clears mode_sup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 10 | Memory address register contents |
| mem_wdata | output | 16 | Memory data register contents for writes |
| mem_rd | output | 1 | Read command |
| mem_wr | output | 1 | Write command |
| pc | output | 10 | Program counter |
| int_en | output | 1 | Global interrupt enable |
| mode_sup | output | 1 | 1 = supervisor mode, 0 = user mode |
| halted | output | 1 | Halt flag |
| flag_z | output | 1 | ALU zero flag |
| flag_n | output | 1 | ALU negative flag |

## Verification
Each instruction has a fixed latency counted in clock edges from the start of its fetch: 5 for register-only work, 6 for a store and 7 for a load or trap. An interrupt entry adds 5 edges before the handler's fetch begins. The read command appears one edge after reset is released. The bench drives and samples on falling edges and counts rising edges from the release of reset. It checks mem_rd, halted and the mid-run interrupt stimulus on the exact edges that these latencies predict. Other results are read from the bench's memory model after halt, when memory writes have landed and the pc has frozen.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
   localparam logic [OPC_W-1:0] OPC_LDIMM = 4'h2;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h5;
   localparam logic [OPC_W-1:0] OPC_TRAP  = 4'h6;
   localparam logic [OPC_W-1:0] OPC_IEN   = 4'h7;
   localparam logic [OPC_W-1:0] OPC_USER  = 4'h8;

   typedef enum logic {
      ALU_ADD,
      ALU_SUB
   } alu_op_e;

   typedef enum logic [3:0] {
      ST_F_MAR,
      ST_F_CMD,
      ST_F_DAT,
      ST_CHECK,
      ST_EXEC,
      ST_X_MAR,
      ST_X_CMD,
      ST_X_DAT,
      ST_X_WR,
      ST_I_SAVE,
      ST_I_WR,
      ST_I_MAR,
      ST_I_CMD,
      ST_I_DAT,
      ST_STOP
   } seq_state_e;

endpackage

// File: rtl/seq_alu.sv
module seq_alu
   import seq_pkg::*;
#(
   parameter int DW           = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  alu_op_e       op,
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   input  logic          upd,
   output logic [DW-1:0] res,
   output logic          zf,
   output logic          nf
);

   localparam logic [DW-1:0] ONE_LSB = {{(DW-1){1'b0}}, 1'b1};

   logic is_sub;
   assign is_sub = (op == ALU_SUB);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DW-1:0] rhs_eff;
         logic [DW-1:0] carry_in;
         assign rhs_eff  = is_sub ? ~rhs : rhs;
         assign carry_in = is_sub ? ONE_LSB : '0;
         assign res      = lhs + rhs_eff + carry_in;
      end else begin : g_split
         logic [DW-1:0] sum_v;
         logic [DW-1:0] dif_v;
         assign sum_v = lhs + rhs;
         assign dif_v = lhs - rhs;
         assign res   = is_sub ? dif_v : sum_v;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zf <= 1'b0;
         nf <= 1'b0;
      end else if (upd) begin
         zf <= (res == '0);
         nf <= res[DW-1];
      end
   end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
   parameter int DW        = 16,
   parameter int RW        = 2,
   parameter bit REG_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [RW-1:0] ra_addr,
   output logic [DW-1:0] ra_data,
   input  logic [RW-1:0] rb_addr,
   output logic [DW-1:0] rb_data
);

   localparam int NREG = 1 << RW;

   logic [DW-1:0] cell_q [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_cell
         logic          hit;
         logic [DW-1:0] q;
         assign hit = we && (waddr == RW'(i));
         if (REG_RESET) begin : g_rst
            always_ff @(posedge clk) begin
               if (!rst_n)   q <= '0;
               else if (hit) q <= wdata;
            end
         end else begin : g_norst
            logic unused_rst;
            assign unused_rst = rst_n;
            always_ff @(posedge clk) begin
               if (hit) q <= wdata;
            end
         end
         assign cell_q[i] = q;
      end
   endgenerate

   assign ra_data = cell_q[ra_addr];
   assign rb_data = cell_q[rb_addr];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seq_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 10,
   parameter int RW        = 2,
   parameter int TRAP_BASE = 1000,
   parameter int TRAP_W    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [DW-1:0] rf_wdata,
   output logic [RW-1:0] rf_ra,
   output logic [RW-1:0] rf_rb,
   input  logic [DW-1:0] rf_da,
   output alu_op_e       alu_op,
   output logic          alu_upd,
   input  logic [DW-1:0] alu_res,
   output logic [AW-1:0] pc,
   output logic          int_en,
   output logic          mode_sup,
   output logic          halted
);

   localparam int              EXT_W     = DW - AW;
   localparam logic [AW-1:0]   VEC_BASE  = AW'(TRAP_BASE);
   localparam logic [AW-1:0]   SAVE_ADDR = '0;
   localparam logic [AW-1:0]   IVEC_ADDR = AW'(1);
   localparam logic [AW-1:0]   PC_STEP   = AW'(1);

   seq_state_e    state_q;
   logic [AW-1:0] pc_q;
   logic [DW-1:0] ir_q;
   logic [AW-1:0] mar_q;
   logic [DW-1:0] mdr_q;
   logic          ie_q;
   logic          sup_q;
   logic          halt_q;

   logic [OPC_W-1:0]  opc;
   logic [RW-1:0]     rsel;
   logic [AW-1:0]     fld;
   logic [TRAP_W-1:0] tsel;
   logic [AW-1:0]     trap_addr;
   logic [DW-1:0]     imm_ext;
   logic [DW-1:0]     pc_ext;
   logic              mem_op;
   logic              alu_instr;

   assign opc       = ir_q[DW-1 -: OPC_W];
   assign rsel      = ir_q[AW +: RW];
   assign fld       = ir_q[AW-1:0];
   assign tsel      = fld[TRAP_W-1:0];
   assign trap_addr = VEC_BASE + {{(AW-TRAP_W){1'b0}}, tsel};
   assign imm_ext   = {{EXT_W{1'b0}}, fld};
   assign pc_ext    = {{EXT_W{1'b0}}, pc_q};
   assign mem_op    = (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_TRAP);
   assign alu_instr = (opc == OPC_ADD) || (opc == OPC_SUB);

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign mem_rd    = (state_q == ST_F_CMD) || (state_q == ST_X_CMD) || (state_q == ST_I_CMD);
   assign mem_wr    = (state_q == ST_X_WR) || (state_q == ST_I_WR);

   assign rf_ra    = rsel;
   assign rf_rb    = fld[RW-1:0];
   assign rf_waddr = rsel;
   assign alu_op   = (opc == OPC_SUB) ? ALU_SUB : ALU_ADD;
   assign alu_upd  = (state_q == ST_EXEC) && alu_instr;

   always_comb begin
      rf_we    = 1'b0;
      rf_wdata = alu_res;
      if (state_q == ST_EXEC) begin
         if (opc == OPC_LDIMM) begin
            rf_we    = 1'b1;
            rf_wdata = imm_ext;
         end else if (alu_instr) begin
            rf_we    = 1'b1;
         end
      end else if (state_q == ST_X_DAT && opc == OPC_LOAD) begin
         rf_we    = 1'b1;
         rf_wdata = mem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_F_MAR;
         pc_q    <= '0;
         ir_q    <= '0;
         mar_q   <= '0;
         mdr_q   <= '0;
         ie_q    <= 1'b0;
         sup_q   <= 1'b1;
         halt_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_F_MAR: begin
               mar_q   <= pc_q;
               state_q <= ST_F_CMD;
            end
            ST_F_CMD: state_q <= ST_F_DAT;
            ST_F_DAT: begin
               ir_q    <= mem_rdata;
               mdr_q   <= mem_rdata;
               state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (irq && ie_q)  state_q <= ST_I_SAVE;
               else if (mem_op)  state_q <= ST_X_MAR;
               else              state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (opc == OPC_HALT) begin
                  halt_q  <= 1'b1;
                  state_q <= ST_STOP;
               end else begin
                  if (opc == OPC_IEN)  ie_q  <= 1'b1;
                  if (opc == OPC_USER) sup_q <= 1'b0;
                  pc_q    <= pc_q + PC_STEP;
                  state_q <= ST_F_MAR;
               end
            end
            ST_X_MAR: begin
               if (opc == OPC_TRAP) begin
                  mar_q   <= trap_addr;
                  state_q <= ST_X_CMD;
               end else if (opc == OPC_STORE) begin
                  mar_q   <= fld;
                  mdr_q   <= rf_da;
                  state_q <= ST_X_WR;
               end else begin
                  mar_q   <= fld;
                  state_q <= ST_X_CMD;
               end
            end
            ST_X_CMD: state_q <= ST_X_DAT;
            ST_X_DAT: begin
               mdr_q <= mem_rdata;
               if (opc == OPC_TRAP) begin
                  pc_q  <= mem_rdata[AW-1:0];
                  sup_q <= 1'b1;
               end else begin
                  pc_q  <= pc_q + PC_STEP;
               end
               state_q <= ST_F_MAR;
            end
            ST_X_WR: begin
               pc_q    <= pc_q + PC_STEP;
               state_q <= ST_F_MAR;
            end
            ST_I_SAVE: begin
               ie_q    <= 1'b0;
               mar_q   <= SAVE_ADDR;
               mdr_q   <= pc_ext;
               state_q <= ST_I_WR;
            end
            ST_I_WR:  state_q <= ST_I_MAR;
            ST_I_MAR: begin
               mar_q   <= IVEC_ADDR;
               state_q <= ST_I_CMD;
            end
            ST_I_CMD: state_q <= ST_I_DAT;
            ST_I_DAT: begin
               mdr_q   <= mem_rdata;
               pc_q    <= mem_rdata[AW-1:0];
               sup_q   <= 1'b1;
               state_q <= ST_F_MAR;
            end
            ST_STOP:  state_q <= ST_STOP;
            default:  state_q <= ST_STOP;
         endcase
      end
   end

   assign pc       = pc_q;
   assign int_en   = ie_q;
   assign mode_sup = sup_q;
   assign halted   = halt_q;

endmodule

// File: rtl/seq_core.sv
module seq_core
   import seq_pkg::*;
#(
   parameter int DW           = 16,
   parameter int AW           = 10,
   parameter int RW           = 2,
   parameter int TRAP_BASE    = 1000,
   parameter int TRAP_W       = 2,
   parameter bit SHARED_ADDER = 1'b1,
   parameter bit REG_RESET    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] pc,
   output logic          int_en,
   output logic          mode_sup,
   output logic          halted,
   output logic          flag_z,
   output logic          flag_n
);

   localparam int MEM_WORDS = 1 << AW;
   localparam int VEC_COUNT = 1 << TRAP_W;

   generate
      if (DW != OPC_W + RW + AW) begin : g_bad_layout
         $error("seq_core: DW must equal opcode + register + operand widths");
      end
      if (TRAP_W > RW && TRAP_W > AW) begin : g_bad_trapw
         $error("seq_core: TRAP_W wider than operand field");
      end
      if (TRAP_BASE + VEC_COUNT > MEM_WORDS || TRAP_BASE < 2) begin : g_bad_vec
         $error("seq_core: trap vectors fall outside memory or over words 0/1");
      end
   endgenerate

   logic          rf_we;
   logic [RW-1:0] rf_waddr;
   logic [DW-1:0] rf_wdata;
   logic [RW-1:0] rf_ra;
   logic [RW-1:0] rf_rb;
   logic [DW-1:0] rf_da;
   logic [DW-1:0] rf_db;
   alu_op_e       alu_op;
   logic          alu_upd;
   logic [DW-1:0] alu_res;

   seq_ctrl #(
      .DW(DW), .AW(AW), .RW(RW), .TRAP_BASE(TRAP_BASE), .TRAP_W(TRAP_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_da(rf_da),
      .alu_op(alu_op), .alu_upd(alu_upd), .alu_res(alu_res),
      .pc(pc), .int_en(int_en), .mode_sup(mode_sup), .halted(halted)
   );

   seq_regfile #(
      .DW(DW), .RW(RW), .REG_RESET(REG_RESET)
   ) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .ra_addr(rf_ra), .ra_data(rf_da), .rb_addr(rf_rb), .rb_data(rf_db)
   );

   seq_alu #(
      .DW(DW), .SHARED_ADDER(SHARED_ADDER)
   ) u_alu (
      .clk(clk), .rst_n(rst_n), .op(alu_op), .lhs(rf_da), .rhs(rf_db),
      .upd(alu_upd), .res(alu_res), .zf(flag_z), .nf(flag_n)
   );

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
   parameter int DW = 16,
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] pc,
   input logic          int_en,
   input logic          mode_sup,
   input logic          halted
);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (pc == '0 && !int_en && mode_sup && !halted && !mem_rd && !mem_wr));

   assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && $stable(mem_addr)));

   assert_single_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_rd && !mem_wr && $stable(pc)));

   assert_int_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_en) |-> (mem_wr && mem_addr == '0 && mem_wdata == {{(DW-AW){1'b0}}, pc}));

endmodule

bind seq_core seq_core_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .int_en(int_en),
   .mode_sup(mode_sup), .halted(halted)
);

// File: tb/sim_seq_core.sv
`timescale 1ns/1ps
module sim_seq_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [9:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_rd, mem_wr;
   logic [9:0]  pc;
   logic        int_en, mode_sup, halted, flag_z, flag_n;

   int checks = 0;
   int fails  = 0;

   logic [15:0] mem [1024];

   always #5 clk = ~clk;

   seq_core u0 (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .pc(pc), .int_en(int_en), .mode_sup(mode_sup), .halted(halted),
      .flag_z(flag_z), .flag_n(flag_n)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   function automatic logic [15:0] ins(input int op, input int r, input int f);
      return {op[3:0], r[1:0], f[9:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq   = 1'b0;
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      repeat (2) @(negedge clk);
   endtask

   task automatic release_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input string req);
      int n = 0;
      while (!halted && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check({req, " halted"}, 32'(halted), 32'd1);
   endtask

   task automatic t_reset();
      hold_reset();
      check("R1 pc", 32'(pc), 32'd0);
      check("R1 int_en", 32'(int_en), 32'd0);
      check("R1 mode_sup", 32'(mode_sup), 32'd1);
      check("R1 halted", 32'(halted), 32'd0);
      check("R1 no command", 32'({mem_rd, mem_wr}), 32'd0);
   endtask

   task automatic t_timing();
      int busy = 0;
      hold_reset();
      mem[0] = ins(2, 1, 'h2A);
      mem[1] = ins(3, 1, 300);
      mem[2] = ins(0, 0, 0);
      release_reset();
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (k == 1) begin
            check("R2 read cmd on edge 1", 32'(mem_rd), 32'd1);
            check("R2 read addr 0", 32'(mem_addr), 32'd0);
         end
         if (k == 2)  check("R2 read one cycle", 32'(mem_rd), 32'd0);
         if (k == 15) check("R6 halt not yet", 32'(halted), 32'd0);
         if (k == 16) check("R7 halt after 5+6+5 edges", 32'(halted), 32'd1);
      end
      check("R4 store result", 32'(mem[300]), 32'h2A);
      check("R7 pc at halt", 32'(pc), 32'd2);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (mem_rd || mem_wr) busy++;
      end
      check("R7 no command after halt", 32'(busy), 32'd0);
      check("R7 pc frozen", 32'(pc), 32'd2);
   endtask

   task automatic t_alu();
      hold_reset();
      mem[200] = 16'h1234;
      mem[0] = ins(2, 0, 5);
      mem[1] = ins(2, 1, 7);
      mem[2] = ins(4, 0, 1);
      mem[3] = ins(3, 0, 100);
      mem[4] = ins(1, 3, 200);
      mem[5] = ins(3, 3, 102);
      mem[6] = ins(2, 2, 3);
      mem[7] = ins(5, 2, 1);
      mem[8] = ins(3, 2, 101);
      mem[9] = ins(0, 0, 0);
      release_reset();
      run_to_halt("R5 alu prog");
      check("R5 add 5+7", 32'(mem[100]), 32'd12);
      check("R5 sub 3-7 wraps", 32'(mem[101]), 32'hFFFC);
      check("R4 load then store", 32'(mem[102]), 32'h1234);
      check("R5 negative flag", 32'(flag_n), 32'd1);
      check("R5 zero flag clear", 32'(flag_z), 32'd0);
      check("R6 pc advanced to halt", 32'(pc), 32'd9);
   endtask

   task automatic t_zero_and_unknown();
      hold_reset();
      mem[103] = 16'hAAAA;
      mem[0] = ins(2, 0, 'h3FF);
      mem[1] = ins(5, 0, 0);
      mem[2] = ins(12, 1, 0);
      mem[3] = ins(2, 1, 5);
      mem[4] = ins(3, 0, 103);
      mem[5] = ins(0, 0, 0);
      release_reset();
      run_to_halt("R3 unknown opcode prog");
      check("R5 zero flag set", 32'(flag_z), 32'd1);
      check("R5 load-imm keeps flags", 32'(flag_n), 32'd0);
      check("R4 imm 0x3FF minus itself", 32'(mem[103]), 32'd0);
      check("R3 unknown opcode advances pc", 32'(pc), 32'd5);
   endtask

   task automatic t_user_mode();
      hold_reset();
      mem[0] = ins(8, 0, 0);
      mem[1] = ins(0, 0, 0);
      release_reset();
      run_to_halt("R11 user prog");
      check("R11 user mode entered", 32'(mode_sup), 32'd0);
   endtask

   task automatic t_trap();
      hold_reset();
      mem[1002] = 16'd50;
      mem[1001] = 16'd60;
      mem[0]  = ins(8, 0, 0);
      mem[1]  = ins(6, 0, 2);
      mem[50] = ins(2, 1, 'h55);
      mem[51] = ins(3, 1, 110);
      mem[52] = ins(0, 0, 0);
      release_reset();
      run_to_halt("R8 trap prog");
      check("R8 handler 2 ran", 32'(mem[110]), 32'h55);
      check("R8 supervisor forced", 32'(mode_sup), 32'd1);
      check("R8 pc in handler", 32'(pc), 32'd52);
   endtask

   task automatic t_trap_then_irq();
      hold_reset();
      mem[1]    = 16'd80;
      mem[1002] = 16'd50;
      mem[0]    = ins(7, 0, 0);
      mem[1]    = 16'd80;
      mem[2]    = ins(0, 0, 0);
      mem[50]   = ins(0, 0, 0);
      mem[80]   = ins(0, 0, 0);
      mem[1]    = 16'd80;
      mem[3]    = ins(0, 0, 0);
      mem[4]    = ins(0, 0, 0);
      mem[5]    = ins(0, 0, 0);
      // program: word 0 enables interrupts, word 2... placed at 9 to avoid vector word 1
      mem[0]    = ins(7, 0, 0);
      mem[9]    = ins(0, 0, 0);
      release_reset();
      run_to_halt("R11 ien prog");
      check("R11 int_en set by enable", 32'(int_en), 32'd1);
      // second run: enable, then trap while request arrives mid-trap
      hold_reset();
      mem[1]    = 16'd80;
      mem[1002] = 16'd50;
      mem[2]    = ins(7, 0, 0);
      mem[3]    = ins(6, 0, 2);
      mem[50]   = ins(0, 0, 0);
      mem[80]   = ins(0, 0, 0);
      mem[0]    = ins(0, 0, 0);
      mem[0]    = {6'b0, 10'd0};
      // start at 2: jump there with trap from 0
      mem[0]    = ins(6, 0, 1);
      mem[1001] = 16'd2;
      release_reset();
      // trap 1 at word 0: 7 edges; enable at 2: 5 edges; trap fetch check at edge 16
      for (int k = 1; k <= 16; k++) @(negedge clk);
      irq = 1'b1;
      run_to_halt("R8 trap not interrupted");
      check("R8 saved pc is handler entry", 32'(mem[0]), 32'd50);
      check("R9 vectored to word 1 target", 32'(pc), 32'd80);
      check("R9 int_en cleared on entry", 32'(int_en), 32'd0);
      irq = 1'b0;
   endtask

   task automatic t_irq_masked();
      hold_reset();
      irq = 1'b1;
      mem[0]   = 16'hBEEF;
      mem[1]   = 16'd80;
      mem[80]  = ins(0, 0, 0);
      mem[5]   = ins(2, 0, 4);
      mem[6]   = ins(3, 0, 130);
      mem[7]   = ins(0, 0, 0);
      mem[2]   = ins(0, 0, 0);
      mem[1001] = 16'd5;
      mem[0]   = ins(6, 0, 1);
      release_reset();
      run_to_halt("R10 masked prog");
      check("R10 word 0 untouched", 32'(mem[0]), 32'(ins(6, 0, 1)));
      check("R10 program completed", 32'(mem[130]), 32'd4);
      check("R10 pc not redirected", 32'(pc), 32'd7);
      irq = 1'b0;
   endtask

   task automatic t_irq();
      hold_reset();
      irq = 1'b1;
      mem[1]    = 16'd80;
      mem[1001] = 16'd4;
      mem[0]    = ins(6, 0, 1);
      mem[4]    = ins(8, 0, 0);
      mem[5]    = ins(7, 0, 0);
      mem[6]    = ins(2, 0, 1);
      mem[7]    = ins(3, 0, 121);
      mem[8]    = ins(0, 0, 0);
      mem[80]   = ins(2, 2, 9);
      mem[81]   = ins(3, 2, 120);
      mem[82]   = ins(0, 0, 0);
      release_reset();
      run_to_halt("R9 irq prog");
      check("R9 saved pc of dropped fetch", 32'(mem[0]), 32'd6);
      check("R9 fetched instruction dropped", 32'(mem[121]), 32'd0);
      check("R9 handler ran", 32'(mem[120]), 32'd9);
      check("R9 supervisor on entry", 32'(mode_sup), 32'd1);
      check("R9 int_en cleared", 32'(int_en), 32'd0);
      check("R9 pc in handler", 32'(pc), 32'd82);
      irq = 1'b0;
   endtask

   initial begin
      #1_500_000;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_timing();
      t_alu();
      t_zero_and_unknown();
      t_user_mode();
      t_trap();
      t_trap_then_irq();
      t_irq_masked();
      t_irq();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule